// File: doc/BRIEF.md
# HDLC Frame Status Capture Register

This block holds the completion status of the most recent frame received on a bit-synchronous (HDLC) receive channel. The receive side flags events as they happen: end of frame, short frame, abort, residual bits, overrun and CRC error. These flags collect in a live character-status register. When the character that carries the end-of-message marker is popped from the receive buffer, the live flags are copied into the frame status register, and the live register starts a fresh frame.

Software reaches the block through a small register port. A read is combinational from `cpu_addr`. A write is accepted on `cpu_wr`. The frame status register is cleared by writing ones to its bits. One level interrupt output reports end of frame when software has enabled it. The block also holds a read-only bit that shows whether the receiver has been enabled by command.

Top module: `hdlc_frame_status`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: A one-cycle pulse on `chr_flag_set` ORs its bits into the live register. That register is read at address 1 with layout bit 7 EOMF, bit 6 short, bit 5 abort, bit 4 residual, bit 3 overrun, bit 2 CRC error, and bits 1:0 read 0. Writes to address 1 are ignored.
- R3: A cycle with `rx_pop` and `rx_pop_eom` both 1 copies the live flags into the frame status register at address 0, with the same bit layout, visible after that clock edge. A pop with `rx_pop_eom`=0 changes nothing.
- R4: On an end-of-message pop, the live register is loaded with that cycle's `chr_flag_set` value, so it becomes 0 when no flags arrive in that cycle.
- R5: Writing address 0 clears each bit written as 1 and leaves each bit written as 0 unchanged. Bits 1:0 always read 0.
- R6: When an end-of-message capture and a write to address 0 fall in the same cycle, the capture wins and no captured bit is cleared.
- R7: `rx_reset_cmd` or `chan_reset_cmd` clears both the frame status register and the live register.
- R8: While `sys_stop` is 1, the frame status register is held at 0 and captures are discarded. It stays 0 after the stop ends.
- R9: While `bit_sync` is 0, the frame status register is held at 0 and reads 0.
- R10: Address 2 bit 0 is the end-of-frame interrupt enable (read/write). `irq` equals EOMF AND enable, delayed by one clock edge, so it falls one cycle after EOMF is cleared.
- R11: Frame status bits 6:2 never assert `irq`, whatever the enable.
- R12: Address 3 bit 0 is set by `rx_enable_cmd` and cleared by `rx_disable_cmd`; disable wins when both are 1. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_sync | input | 1 | Channel is in bit-synchronous mode |
| sys_stop | input | 1 | System stop mode |
| rx_reset_cmd | input | 1 | Receiver reset command pulse |
| chan_reset_cmd | input | 1 | Channel reset command pulse |
| rx_enable_cmd | input | 1 | Receiver enable command pulse |
| rx_disable_cmd | input | 1 | Receiver disable command pulse |
| chr_flag_set | input | 6 | Status flag events {EOMF, short, abort, residual, overrun, CRC} |
| rx_pop | input | 1 | A character is read from the receive buffer |
| rx_pop_eom | input | 1 | The popped character ends the frame |
| cpu_addr | input | 2 | Register address |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr` |
| irq | output | 1 | End-of-frame interrupt level |

## Verification
A capture that goes wrong shows at address 0 on the first read after the end-of-message pop. A live register that is not cleared shows at address 1 in that same cycle, and it corrupts the next frame's captured value. Faulty clear priority (write against capture, stop, mode or reset) shows as a wrong frame status one edge after the conflicting cycle. An interrupt gating fault shows on `irq` exactly two edges after the pop or the write that caused it.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
    localparam int REG_W  = 8;
    localparam int RSV_W  = 2;
    localparam int FLAG_W = REG_W - RSV_W;
    localparam int IDX_EOMF = FLAG_W - 1;

    typedef enum logic [1:0] {
        A_FRAME  = 2'd0,
        A_LIVE   = 2'd1,
        A_CTRL   = 2'd2,
        A_RXSTAT = 2'd3
    } addr_e;
endpackage

// File: rtl/hfs_live_flags.sv
module hfs_live_flags #(
    parameter int FLAG_W = hfs_pkg::FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              eom_pop,
    input  logic [FLAG_W-1:0] set_flags,
    output logic [FLAG_W-1:0] live_q
);
    logic [FLAG_W-1:0] live_d;

    always_comb begin
        live_d = live_q | set_flags;
        if (eom_pop) live_d = set_flags;
        if (clr)     live_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end

    // R4: an end-of-message pop restarts the live flags
    assert_live_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eom_pop && !clr) |=> live_q == $past(set_flags));

    // R7: command reset empties the live flags
    assert_live_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> live_q == '0);
endmodule

// File: rtl/hfs_frame_reg.sv
module hfs_frame_reg #(
    parameter int FLAG_W = hfs_pkg::FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              capture,
    input  logic [FLAG_W-1:0] live_flags,
    input  logic              w1c_en,
    input  logic [FLAG_W-1:0] w1c_mask,
    output logic [FLAG_W-1:0] fst_q
);
    logic [FLAG_W-1:0] fst_d;

    always_comb begin
        fst_d = fst_q;
        if (w1c_en)  fst_d = fst_q & ~w1c_mask;
        if (capture) fst_d = live_flags;
        if (clr_all) fst_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fst_q <= '0;
        else        fst_q <= fst_d;
    end

    // R3 and R6: capture lands even when a clear write shares the cycle
    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !clr_all) |=> fst_q == $past(live_flags));

    // R5: a written one never survives the edge
    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_en && !capture && !clr_all) |=> (fst_q & $past(w1c_mask)) == '0);

    // R8, R9: forced clear holds the register at zero
    assert_forced_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> fst_q == '0);
endmodule

// File: rtl/hdlc_frame_status.sv
module hdlc_frame_status
    import hfs_pkg::*;
#(
    parameter int REG_W  = hfs_pkg::REG_W,
    parameter int RSV_W  = hfs_pkg::RSV_W,
    parameter int ADDR_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_sync,
    input  logic               sys_stop,
    input  logic               rx_reset_cmd,
    input  logic               chan_reset_cmd,
    input  logic               rx_enable_cmd,
    input  logic               rx_disable_cmd,
    input  logic [REG_W-RSV_W-1:0] chr_flag_set,
    input  logic               rx_pop,
    input  logic               rx_pop_eom,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_wr,
    input  logic [REG_W-1:0]   cpu_wdata,
    output logic [REG_W-1:0]   cpu_rdata,
    output logic               irq
);
    localparam int FW = REG_W - RSV_W;
    localparam int EOMF = FW - 1;

    typedef struct packed {
        logic ie;
        logic rxen;
        logic irq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [FW-1:0] live_q, fst_q;
    logic eom_pop, cmd_reset, clr_all, wr_frame;

    assign eom_pop   = rx_pop & rx_pop_eom;
    assign cmd_reset = rx_reset_cmd | chan_reset_cmd;
    assign clr_all   = cmd_reset | sys_stop | ~bit_sync;
    assign wr_frame  = cpu_wr && (cpu_addr == ADDR_W'(A_FRAME));

    hfs_live_flags #(.FLAG_W(FW)) u_live (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cmd_reset),
        .eom_pop   (eom_pop),
        .set_flags (chr_flag_set),
        .live_q    (live_q)
    );

    hfs_frame_reg #(.FLAG_W(FW)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all    (clr_all),
        .capture    (eom_pop),
        .live_flags (live_q),
        .w1c_en     (wr_frame),
        .w1c_mask   (cpu_wdata[REG_W-1:RSV_W]),
        .fst_q      (fst_q)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (cpu_wr && cpu_addr == ADDR_W'(A_CTRL)) ctl_d.ie = cpu_wdata[0];
        if (rx_enable_cmd)  ctl_d.rxen = 1'b1;
        if (rx_disable_cmd) ctl_d.rxen = 1'b0;
        ctl_d.irq = fst_q[EOMF] & ctl_q.ie;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            ADDR_W'(A_FRAME):  cpu_rdata = {fst_q, {RSV_W{1'b0}}};
            ADDR_W'(A_LIVE):   cpu_rdata = {live_q, {RSV_W{1'b0}}};
            ADDR_W'(A_CTRL):   cpu_rdata[0] = ctl_q.ie;
            default:           cpu_rdata[0] = ctl_q.rxen;
        endcase
    end

    assign irq = ctl_q.irq;

    // R10, R11: interrupt only follows EOMF gated by its enable
    assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(fst_q[EOMF] & ctl_q.ie));

    // R12: disable command wins
    assert_rx_disable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_disable_cmd |=> !ctl_q.rxen);

    // R12: enable command alone sets the status
    assert_rx_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable_cmd && !rx_disable_cmd) |=> ctl_q.rxen);
endmodule

// File: tb/hdlc_frame_status_test.sv
module hdlc_frame_status_test;
    logic clk = 0, rst_n = 0;
    logic bit_sync = 1, sys_stop = 0, rx_reset_cmd = 0, chan_reset_cmd = 0;
    logic rx_enable_cmd = 0, rx_disable_cmd = 0;
    logic [5:0] chr_flag_set = '0;
    logic rx_pop = 0, rx_pop_eom = 0;
    logic [1:0] cpu_addr = 0;
    logic cpu_wr = 0;
    logic [7:0] cpu_wdata = 0;
    logic [7:0] cpu_rdata;
    logic irq;
    int errors = 0, checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hdlc_frame_status uut (
        .clk(clk), .rst_n(rst_n), .bit_sync(bit_sync), .sys_stop(sys_stop),
        .rx_reset_cmd(rx_reset_cmd), .chan_reset_cmd(chan_reset_cmd),
        .rx_enable_cmd(rx_enable_cmd), .rx_disable_cmd(rx_disable_cmd),
        .chr_flag_set(chr_flag_set), .rx_pop(rx_pop), .rx_pop_eom(rx_pop_eom),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [7:0] exp);
        cpu_addr = a;
        #0.5;
        chk(req, cpu_rdata, exp);
    endtask

    // strobes applied for one cycle, released at the next falling edge
    task automatic cyc();
        @(negedge clk);
        chr_flag_set = '0; rx_pop = 0; rx_pop_eom = 0; cpu_wr = 0;
        rx_reset_cmd = 0; chan_reset_cmd = 0; rx_enable_cmd = 0; rx_disable_cmd = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1; cyc();
    endtask

    task automatic put_flags(input logic [5:0] f);
        chr_flag_set = f; cyc();
    endtask

    task automatic pop(input logic eom);
        rx_pop = 1; rx_pop_eom = eom; cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(0, "R1", 8'h00); rd(1, "R1", 8'h00); rd(2, "R1", 8'h00); rd(3, "R1", 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);

        wr(2, 8'h01);
        rd(2, "R10 enable", 8'h01);

        // sweep every flag pattern through capture, clear and interrupt
        for (int p = 0; p < 64; p++) begin
            logic [5:0] m;
            m = 6'((p * 37 + 5) & 63);
            put_flags(6'(p));
            rd(1, "R2 live", 8'(p << 2));
            pop(1'b0);
            rd(0, "R3 no eom", 8'h00);
            rd(1, "R3 no eom live", 8'(p << 2));
            pop(1'b1);
            rd(0, "R3 capture", 8'(p << 2));
            rd(1, "R4 live cleared", 8'h00);
            chk("R10 irq lag", {7'b0, irq}, 8'h00);
            cyc();
            chk("R10 R11 irq", {7'b0, irq}, {7'b0, p[5]});
            wr(0, {m, 2'b11});
            rd(0, "R5 w1c", {6'(p) & ~m, 2'b00});
            cyc();
            chk("R10 irq follows", {7'b0, irq}, {7'b0, p[5] & ~m[5]});
            wr(0, 8'hFF);
            rd(0, "R5 all clear", 8'h00);
        end

        // R2 writes to live ignored, accumulation
        put_flags(6'b000001); put_flags(6'b010000);
        wr(1, 8'h00);
        rd(1, "R2 accumulate", 8'h44);
        // R4 flags arriving with the eom pop start the next frame
        chr_flag_set = 6'b000010; rx_pop = 1; rx_pop_eom = 1; cyc();
        rd(0, "R4 captured", 8'h44);
        rd(1, "R4 new frame", 8'h08);
        wr(0, 8'hFF); pop(1'b1); wr(0, 8'hFF);

        // R6 capture vs write in the same cycle
        put_flags(6'b101010);
        rx_pop = 1; rx_pop_eom = 1; cpu_addr = 0; cpu_wdata = 8'hFF; cpu_wr = 1; cyc();
        rd(0, "R6 capture wins", 8'hA8);

        // R7 reset commands
        put_flags(6'b000111);
        rx_reset_cmd = 1; cyc();
        rd(0, "R7 rx reset fst", 8'h00); rd(1, "R7 rx reset live", 8'h00);
        put_flags(6'b110000); pop(1'b1); put_flags(6'b000011);
        chan_reset_cmd = 1; cyc();
        rd(0, "R7 chan reset fst", 8'h00); rd(1, "R7 chan reset live", 8'h00);

        // R8 system stop
        put_flags(6'b100100); pop(1'b1);
        rd(0, "R8 pre", 8'h90);
        sys_stop = 1; cyc();
        rd(0, "R8 stop clears", 8'h00);
        put_flags(6'b011000); pop(1'b1); cyc();
        rd(0, "R8 stop blocks", 8'h00);
        chk("R8 irq", {7'b0, irq}, 8'h00);
        sys_stop = 0; cyc();
        rd(0, "R8 after stop", 8'h00);

        // R9 non bit-sync mode
        put_flags(6'b100001); pop(1'b1);
        rd(0, "R9 pre", 8'h84);
        bit_sync = 0; cyc();
        rd(0, "R9 mode zero", 8'h00);
        put_flags(6'b100001); pop(1'b1);
        rd(0, "R9 no capture", 8'h00);
        bit_sync = 1; cyc();

        // R11 non-EOMF bits never interrupt; R10 enable off masks EOMF
        put_flags(6'b011111); pop(1'b1); cyc(); cyc();
        chk("R11 no irq", {7'b0, irq}, 8'h00);
        wr(0, 8'hFF);
        wr(2, 8'h00);
        put_flags(6'b100000); pop(1'b1); cyc(); cyc();
        chk("R10 masked", {7'b0, irq}, 8'h00);
        wr(2, 8'h01); cyc();
        chk("R10 enable late", {7'b0, irq}, 8'h01);
        wr(0, 8'h80);
        chk("R10 falls lag", {7'b0, irq}, 8'h01);
        cyc();
        chk("R10 fallen", {7'b0, irq}, 8'h00);

        // R12 receiver enable status
        wr(3, 8'h01);
        rd(3, "R12 write ignored", 8'h00);
        rx_enable_cmd = 1; cyc();
        rd(3, "R12 enabled", 8'h01);
        wr(3, 8'h00);
        rd(3, "R12 write ignored 2", 8'h01);
        rx_enable_cmd = 1; rx_disable_cmd = 1; cyc();
        rd(3, "R12 disable wins", 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule